// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each received frame, whether its 48-bit destination address should be kept or dropped. The receive path hands the address over one byte per cycle in wire order through a valid/ready pair. One cycle after the sixth byte is taken, the block raises a one-cycle decision strobe together with the accept flag.

Group (multicast) addresses are judged by a 512-entry, one-bit-wide hash table. The index comes from a CRC-32 that is accumulated over the six address bytes while they arrive. Individual (unicast) addresses are judged by an exact comparison against one station address. The all-ones broadcast address always passes, and a promiscuous input lets everything pass.

The host programs the table one entry at a time with a single strobe carrying an index and a set/clear value. After reset the block sweeps the table to zero on its own. During that sweep it holds its byte input not ready.

Top module: `mhf_filter`

## Requirements
- R1: After reset every table entry reads as zero. While the clearing sweep runs (at most 512 cycles), `in_ready` is low. After the sweep, a group address other than broadcast is rejected when promiscuous mode is off.
- R2: A write strobe with `cfg_data[9]`=1 sets the entry indexed by `cfg_data[8:0]`, and one with `cfg_data[9]`=0 clears it. Writes affect only lookups whose sixth byte is taken on a later edge.
- R3: The table index is computed as follows. Run a CRC-32 with the reflected polynomial 0xEDB88320, starting from 0xFFFFFFFF, over the six bytes, taking each byte least significant bit first. Apply no final inversion. Index bit 8 is CRC register bit 0, index bit 7 is register bit 1, and so on down to index bit 0, which is register bit 8.
- R4: An address whose first byte has bit 0 set is a group address, and it is accepted exactly when its table entry is set. An address with bit 0 of the first byte clear never consults the table.
- R5: A unicast address is accepted exactly when all six bytes equal the station address. Byte 0 is `station_lo[7:0]`, byte 1 is `station_lo[15:8]`, byte 2 is `station_lo[23:16]`, byte 3 is `station_lo[31:24]`, byte 4 is `station_hi[7:0]` and byte 5 is `station_hi[15:8]`.
- R6: The address FF:FF:FF:FF:FF:FF is accepted whatever the table holds.
- R7: When `promisc_en` is high at the edge that takes the sixth byte, the address is accepted.
- R8: `dec_valid` is high for exactly one cycle, the cycle that follows the edge after the sixth byte is taken. `in_ready` is low between those two edges.
- R9: Once every one of the 512 entries has been set, every group address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle table write strobe |
| cfg_data | input | 10 | [8:0] entry index, [9] value to write |
| promisc_en | input | 1 | Accept every address |
| station_lo | input | 32 | Station address bytes 0..3, byte 0 in [7:0] |
| station_hi | input | 16 | Station address bytes 4..5, byte 4 in [7:0] |
| in_valid | input | 1 | Address byte valid |
| in_byte | input | 8 | Address byte, wire order |
| in_ready | output | 1 | Block can take a byte |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Decision: 1 = keep frame |

## Verification
The hardest situation to reach from the ports is a group address landing on one particular table entry. The CRC scatters addresses over all 512 indices, so random addresses almost never hit the few entries the host has set. The bench therefore computes the index of every random group address itself and sets or clears exactly that entry before sending the address. This drives both outcomes deliberately. It also clears and re-sets single entries, fills the whole table, and sends unicast addresses that differ from the station in only one byte.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned IDX_W      = 9;
  localparam int unsigned TBL_DEPTH  = 1 << IDX_W;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] crc_index(input logic [31:0] c);
    logic [IDX_W-1:0] ix;
    for (int j = 0; j < IDX_W; j++) begin
      ix[IDX_W-1-j] = c[j];
    end
    return ix;
  endfunction
endpackage

// File: rtl/mhf_crc_lane.sv
module mhf_crc_lane
  import mhf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  input  logic        last,
  input  logic [7:0]  data,
  output logic [31:0] crc_next
);
  logic [31:0] crc_q;

  assign crc_next = crc_byte(crc_q, data);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_SEED;
    end else if (step) begin
      crc_q <= last ? CRC_SEED : crc_next;
    end
  end
endmodule

// File: rtl/mhf_addr_stage.sv
module mhf_addr_stage #(
  parameter int unsigned NBYTES = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic [7:0]           data,
  input  logic [NBYTES*8-1:0]  station,
  output logic                 last,
  output logic                 grp_now,
  output logic                 match_now,
  output logic                 bcast_now
);
  localparam int unsigned CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(NBYTES - 1);

  logic [CW-1:0] cnt_q;
  logic          grp_q, match_q, bcast_q;
  logic          first;
  logic [7:0]    st_byte;

  assign first     = (cnt_q == '0);
  assign last      = (cnt_q == LAST_CNT);
  assign st_byte   = station[cnt_q*8 +: 8];
  assign grp_now   = first ? data[0] : grp_q;
  assign match_now = (first | match_q) & (data == st_byte);
  assign bcast_now = (first | bcast_q) & (data == 8'hFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      grp_q   <= 1'b0;
      match_q <= 1'b0;
      bcast_q <= 1'b0;
    end else if (step) begin
      cnt_q   <= last ? '0 : cnt_q + 1'b1;
      grp_q   <= grp_now;
      match_q <= match_now;
      bcast_q <= bcast_now;
    end
  end
endmodule

// File: rtl/mhf_bit_table.sv
module mhf_bit_table #(
  parameter int unsigned IW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_val,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_bit,
  output logic          busy
);
  localparam int unsigned DEPTH = 1 << IW;

  logic          mem [DEPTH];
  logic [IW-1:0] clr_idx;
  logic          clearing;
  logic          we;
  logic [IW-1:0] waddr;
  logic          wdata;

  assign busy  = clearing;
  assign we    = clearing | wr_en;
  assign waddr = clearing ? clr_idx : wr_idx;
  assign wdata = clearing ? 1'b0 : wr_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
    end else if (clearing) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == IW'(DEPTH - 1)) clearing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_bit <= mem[rd_idx];
  end
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [9:0]  cfg_data,
  input  logic        promisc_en,
  input  logic [31:0] station_lo,
  input  logic [15:0] station_hi,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        dec_valid,
  output logic        dec_accept
);
  logic              step, last;
  logic              grp_now, match_now, bcast_now;
  logic [31:0]       crc_next;
  logic [IDX_W-1:0]  look_idx;
  logic              tbl_bit, tbl_busy, fire;
  logic              look_pend, look_grp, look_match, look_bcast, look_promisc;

  assign in_ready = ~look_pend & ~tbl_busy;
  assign step     = in_valid & in_ready;
  assign fire     = step & last;
  assign look_idx = crc_index(crc_next);

  mhf_addr_stage #(.NBYTES(ADDR_BYTES)) addr_i (
    .clk(clk), .rst(rst), .step(step), .data(in_byte),
    .station({station_hi, station_lo}),
    .last(last), .grp_now(grp_now), .match_now(match_now), .bcast_now(bcast_now)
  );

  mhf_crc_lane crc_i (
    .clk(clk), .rst(rst), .step(step), .last(last), .data(in_byte),
    .crc_next(crc_next)
  );

  mhf_bit_table #(.IW(IDX_W)) tbl_i (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr), .wr_idx(cfg_data[IDX_W-1:0]), .wr_val(cfg_data[IDX_W]),
    .rd_en(fire), .rd_idx(look_idx), .rd_bit(tbl_bit), .busy(tbl_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      look_pend    <= 1'b0;
      look_grp     <= 1'b0;
      look_match   <= 1'b0;
      look_bcast   <= 1'b0;
      look_promisc <= 1'b0;
    end else begin
      look_pend <= fire;
      if (fire) begin
        look_grp     <= grp_now;
        look_match   <= match_now;
        look_bcast   <= bcast_now;
        look_promisc <= promisc_en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= look_pend;
      dec_accept <= look_pend & (look_promisc | look_bcast |
                                 (look_grp & tbl_bit) | (~look_grp & look_match));
    end
  end
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic dec_valid,
  input logic dec_accept,
  input logic look_pend,
  input logic look_grp,
  input logic look_match,
  input logic look_bcast,
  input logic look_promisc
);
  a_r8_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
  a_r8_ready_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |=> dec_valid);
  a_r8_lookup_to_valid: assert property (@(posedge clk) disable iff (rst)
    look_pend |=> dec_valid);
  a_r6_broadcast: assert property (@(posedge clk) disable iff (rst)
    look_pend && look_bcast |=> dec_accept);
  a_r7_promisc: assert property (@(posedge clk) disable iff (rst)
    look_pend && look_promisc |=> dec_accept);
  a_r5_unicast_miss: assert property (@(posedge clk) disable iff (rst)
    look_pend && !look_grp && !look_match && !look_promisc |=> !dec_accept);
  a_r5_unicast_hit: assert property (@(posedge clk) disable iff (rst)
    look_pend && !look_grp && look_match |=> dec_accept);
endmodule

bind mhf_filter mhf_filter_chk chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .look_pend(look_pend), .look_grp(look_grp),
  .look_match(look_match), .look_bcast(look_bcast), .look_promisc(look_promisc)
);

// File: tb/mhf_filter_tb.sv
module mhf_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [9:0]  cfg_data = '0;
  logic        promisc_en = 1'b0;
  logic [31:0] station_lo = '0;
  logic [15:0] station_hi = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready, dec_valid, dec_accept;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit model_tbl [512];

  always #10 clk = ~clk;

  mhf_filter dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .promisc_en(promisc_en), .station_lo(station_lo), .station_hi(station_hi),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [8:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [8:0] ix;
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ a[8*k + b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    for (int j = 0; j < 9; j++) ix[8-j] = c[j];
    return ix;
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    if (promisc_en) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[0]) return model_tbl[ref_index(a)];
    return a == {station_hi, station_lo};
  endfunction

  task automatic tbl_write(input int idx, input bit val);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_data = {val, 9'(idx)};
    @(negedge clk);
    cfg_wr = 1'b0;
    model_tbl[idx] = val;
  endtask

  task automatic send(input logic [47:0] a, input string req);
    logic exp;
    exp = ref_accept(a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = a[8*k +: 8];
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 ready low during lookup", in_ready, 1'b0);
    @(negedge clk);
    check("R8 valid", dec_valid, 1'b1);
    check(req, dec_accept, exp);
    @(negedge clk);
    check("R8 valid one cycle", dec_valid, 1'b0);
  endtask

  function automatic logic [47:0] rnd_addr(input bit grp);
    logic [47:0] a;
    a = {$urandom(), $urandom()};
    a[0] = grp;
    return a;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) model_tbl[i] = 1'b0;
    station_lo = 32'h44332210;
    station_hi = 16'h6655;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready low while clearing", in_ready, 1'b0);
    check("R8 no valid after reset", dec_valid, 1'b0);
    while (!in_ready) @(negedge clk);

    // R1: empty table rejects group addresses
    for (int i = 0; i < 8; i++) send(rnd_addr(1'b1), "R1 empty table");
    // R6: broadcast with empty table
    send(48'hFFFF_FFFF_FFFF, "R6 broadcast");
    // R5: exact station hit, then single-byte misses
    send({station_hi, station_lo}, "R5 station match");
    for (int k = 0; k < 6; k++) begin
      a = {station_hi, station_lo};
      a[8*k + 3] = ~a[8*k + 3];
      send(a, "R5 one byte differs");
    end
    // R2/R3/R4: set the entry of a group address, then clear it
    for (int i = 0; i < 40; i++) begin
      a = rnd_addr(1'b1);
      tbl_write(int'(ref_index(a)), 1'b1);
      send(a, "R3 R4 entry set");
      tbl_write(int'(ref_index(a)), 1'b0);
      send(a, "R2 entry cleared");
    end
    // R7: promiscuous
    promisc_en = 1'b1;
    send(rnd_addr(1'b1), "R7 promisc group");
    send(rnd_addr(1'b0), "R7 promisc unicast");
    promisc_en = 1'b0;
    // R9: fill whole table
    for (int i = 0; i < 512; i++) tbl_write(i, 1'b1);
    for (int i = 0; i < 30; i++) send(rnd_addr(1'b1), "R9 all set");
    // R4: unicast never uses the table even when full
    for (int i = 0; i < 20; i++) send(rnd_addr(1'b0), "R4 unicast ignores table");
    // mixed random traffic with random table edits
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 2) == 0) tbl_write($urandom_range(0, 511), 1'($urandom_range(0, 1)));
      promisc_en = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 4) == 0) send({station_hi, station_lo}, "R5 random station");
      else send(rnd_addr(1'($urandom_range(0, 1))), "R3 random mix");
    end
    promisc_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule